// File: doc/BRIEF.md
# Streaming Horizontal Max-Pool Reducer

This block reduces a raster stream of multi-channel pixels along the row direction. Each input word carries one pixel for a group of channels: several signed 16-bit lanes side by side. Pixels arrive one channel group (tile) at a time. Within a tile they come row by row, and within a row column by column. The block splits every row into non-overlapping windows whose width is set at run time. For each window it forwards one word holding the signed maximum of each lane.

A start pulse latches the frame geometry: tile count, row count, row width and window width. Input words are then taken through a valid/ready handshake. A single holding register keeps a running per-lane maximum, and results go out through a one-entry valid/ready output slot. When that slot is full and the sink stalls, the block stops accepting input, so nothing is dropped or repeated. After the last pixel of the last tile has been accepted, the block leaves the busy state and raises a sticky done flag. The flag clears at the next start.

Top module: `hpool_reducer`

## Requirements
- R1: Each output word is, lane by lane, the signed 16-bit maximum of the input words in one window. Lane k occupies bits 16k+15 down to 16k of the word.
- R2: The first column of every window loads the running value straight from the input. No value from an earlier window, row or tile affects a later window's result.
- R3: Exactly one output word is produced per window, in arrival order, giving tiles*rows*cols/win words per frame. The output becomes valid only in the cycle after an accepted input beat that closes a window.
- R4: With a window width of 1, every input word is forwarded unchanged.
- R5: While the output word is valid and out_ready_i is low, in_ready_o is low.
- R6: While the output word is valid and not taken, it stays valid and its data does not change.
- R7: With out_ready_i held high, one input word is accepted in every cycle that in_valid_i is high during a frame.
- R8: in_ready_o is low while the block is idle. The block accepts start_i only when idle. After the last input beat of the frame, busy_o falls and done_o rises, and done_o stays high until the next start.
- R9: After reset, out_valid_o, in_ready_o, busy_o and done_o are all low.
- R10: The configuration is sampled at the start pulse. Changing the configuration inputs during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a frame and samples the configuration (used only when idle) |
| cfg_tiles_i | input | 16 | Number of channel tiles, at least 1 |
| cfg_rows_i | input | 16 | Rows per tile, at least 1 |
| cfg_cols_i | input | 16 | Pixels per row, a nonzero multiple of the window width |
| cfg_win_i | input | 16 | Window width in pixels, at least 1 |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Block can take an input word |
| in_data_i | input | 128 | Input pixel word, 8 signed 16-bit lanes |
| out_valid_o | output | 1 | Reduced word valid |
| out_ready_i | input | 1 | Sink takes the reduced word |
| out_data_o | output | 128 | Reduced word, 8 signed 16-bit lanes |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Last input beat of the frame has been taken (sticky) |

## Verification
The bench builds the block with its default 8 lanes of 16 bits, so the full 128-bit word is exercised. The window widths used are 1, 2, 3 and 4 across several tile and row counts. One data pattern alternates windows of the largest and smallest signed values, which exposes any running maximum that leaks across a window or row boundary, as well as any unsigned comparison. A periodic stall of the sink combined with gaps on the source reaches the backpressure and hold-stable cases. One frame also rewrites the configuration inputs after start to show that they were sampled.

// File: rtl/hpool_pkg.sv
package hpool_pkg;
  parameter int unsigned CFG_W = 16;

  typedef struct packed {
    logic [CFG_W-1:0] tiles;
    logic [CFG_W-1:0] rows;
    logic [CFG_W-1:0] cols;
    logic [CFG_W-1:0] win;
  } pool_cfg_t;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_state_e;
endpackage

// File: rtl/hpool_lane_max.sv
module hpool_lane_max #(
  parameter int unsigned LANE_W = 16
) (
  input  logic [LANE_W-1:0] held_i,
  input  logic [LANE_W-1:0] incoming_i,
  input  logic              fresh_i,
  output logic [LANE_W-1:0] merged_o
);
  logic held_wins;

  always_comb begin
    held_wins = $signed(held_i) > $signed(incoming_i);
    if (fresh_i) merged_o = incoming_i;
    else         merged_o = held_wins ? held_i : incoming_i;
  end
endmodule

// File: rtl/hpool_seq.sv
module hpool_seq
  import hpool_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  pool_cfg_t cfg_i,
  input  logic      beat_i,
  output logic      busy_o,
  output logic      done_o,
  output logic      win_first_o,
  output logic      win_last_o
);
  run_state_e       state_q;
  pool_cfg_t        cfg_q;
  logic [CFG_W-1:0] phase_q, col_q, row_q, tile_q;
  logic             col_end, row_end, tile_end;

  assign col_end     = col_q  == cfg_q.cols  - CFG_W'(1);
  assign row_end     = row_q  == cfg_q.rows  - CFG_W'(1);
  assign tile_end    = tile_q == cfg_q.tiles - CFG_W'(1);
  assign win_first_o = phase_q == '0;
  assign win_last_o  = phase_q == cfg_q.win - CFG_W'(1);
  assign busy_o      = state_q == RUN_BUSY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RUN_IDLE;
      cfg_q   <= '0;
      phase_q <= '0;
      col_q   <= '0;
      row_q   <= '0;
      tile_q  <= '0;
      done_o  <= 1'b0;
    end else if (state_q == RUN_IDLE) begin
      if (start_i) begin
        state_q <= RUN_BUSY;
        cfg_q   <= cfg_i;
        phase_q <= '0;
        col_q   <= '0;
        row_q   <= '0;
        tile_q  <= '0;
        done_o  <= 1'b0;
      end
    end else if (beat_i) begin
      phase_q <= win_last_o ? '0 : phase_q + CFG_W'(1);
      if (col_end) begin
        col_q   <= '0;
        phase_q <= '0;  // realign windows at each row start
        if (row_end) begin
          row_q <= '0;
          if (tile_end) begin
            tile_q  <= '0;
            state_q <= RUN_IDLE;
            done_o  <= 1'b1;
          end else begin
            tile_q <= tile_q + CFG_W'(1);
          end
        end else begin
          row_q <= row_q + CFG_W'(1);
        end
      end else begin
        col_q <= col_q + CFG_W'(1);
      end
    end
  end
endmodule

// File: rtl/hpool_out_slot.sv
module hpool_out_slot #(
  parameter int unsigned WORD_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hpool_reducer.sv
module hpool_reducer
  import hpool_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_tiles_i,
  input  logic [CFG_W-1:0]  cfg_rows_i,
  input  logic [CFG_W-1:0]  cfg_cols_i,
  input  logic [CFG_W-1:0]  cfg_win_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              busy_o,
  output logic              done_o
);
  pool_cfg_t         cfg;
  logic              beat, win_first, win_last, slot_free, push;
  logic [WORD_W-1:0] hold_q, merged;

  assign cfg = '{tiles: cfg_tiles_i, rows: cfg_rows_i, cols: cfg_cols_i, win: cfg_win_i};

  hpool_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cfg_i       (cfg),
    .beat_i      (beat),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .win_first_o (win_first),
    .win_last_o  (win_last)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    hpool_lane_max #(.LANE_W(LANE_W)) u_max (
      .held_i     (hold_q[k*LANE_W +: LANE_W]),
      .incoming_i (in_data_i[k*LANE_W +: LANE_W]),
      .fresh_i    (win_first),
      .merged_o   (merged[k*LANE_W +: LANE_W])
    );
  end

  assign in_ready_o = busy_o && slot_free;
  assign beat       = in_valid_i && in_ready_o;
  assign push       = beat && win_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= '0;
    else if (beat && !win_last) hold_q <= merged;
  end

  hpool_out_slot #(.WORD_W(WORD_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (merged),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .free_o  (slot_free)
  );
endmodule

// File: rtl/hpool_reducer_chk.sv
module hpool_reducer_chk #(
  parameter int unsigned WORD_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_data_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r5_hold_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  a_r6_out_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  a_r3_out_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));

  a_r8_idle_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> busy_o);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind hpool_reducer hpool_reducer_chk #(.WORD_W(LANES * LANE_W)) u_chk (.*);

// File: tb/hpool_reducer_test.sv
module hpool_reducer_test;
  localparam int W = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [15:0]   cfg_tiles_i = '0, cfg_rows_i = '0, cfg_cols_i = '0, cfg_win_i = '0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [W-1:0]  in_data_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [W-1:0]  out_data_o;
  logic          busy_o, done_o;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] in_mem [0:511];
  logic [W-1:0] exp_mem [0:511];
  logic [31:0]  seed = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  hpool_reducer uut (.*);

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:15];
  endfunction

  task automatic build(input int tiles, rows, cols, win, dmode);
    int n = tiles * rows * cols;
    for (int i = 0; i < n; i++) begin
      int c = i % cols;
      for (int k = 0; k < 8; k++) begin
        if (dmode == 0) in_mem[i][16*k +: 16] = rnd16();
        else if (((c / win) + (i / cols)) % 2 == 0) in_mem[i][16*k +: 16] = 16'h7fff;
        else in_mem[i][16*k +: 16] = 16'h8000 + 16'(c + k);
      end
    end
    for (int o = 0; o < n / win; o++) begin
      for (int k = 0; k < 8; k++) begin
        logic signed [15:0] m = 16'sh8000;
        for (int j = 0; j < win; j++) begin
          logic signed [15:0] v = in_mem[o*win + j][16*k +: 16];
          if (v > m) m = v;
        end
        exp_mem[o][16*k +: 16] = m;
      end
    end
  endtask

  task automatic run_frame(input int tiles, rows, cols, win, dmode, smode, input bit alt_cfg, input string tag);
    int n_in = tiles * rows * cols;
    int n_out = n_in / win;
    int sent = 0, got = 0, cyc = 0, v5 = 0, v6 = 0, v7 = 0;
    bit stalled = 0;
    logic [W-1:0] prev = '0;
    build(tiles, rows, cols, win, dmode);
    @(negedge clk_i);
    check(in_ready_o == 1'b0, "R8 idle in_ready", W'(in_ready_o), W'(0));
    cfg_tiles_i = 16'(tiles); cfg_rows_i = 16'(rows);
    cfg_cols_i = 16'(cols); cfg_win_i = 16'(win);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (alt_cfg) begin
      cfg_tiles_i = 16'd1; cfg_rows_i = 16'd1; cfg_cols_i = 16'd2; cfg_win_i = 16'd2;
    end
    while ((sent < n_in || got < n_out) && cyc < 5000) begin
      out_ready_i = (smode == 0) ? 1'b1 : (cyc % 3 != 0);
      in_valid_i  = (sent < n_in) && ((smode == 0) || (cyc % 5 != 4));
      in_data_i   = in_mem[sent < n_in ? sent : 0];
      #1;
      if (stalled && (!out_valid_o || out_data_o != prev)) v6++;
      if (out_valid_o && !out_ready_i) begin
        if (in_ready_o) v5++;
        stalled = 1; prev = out_data_o;
      end else stalled = 0;
      if (smode == 0 && in_valid_i && !in_ready_o) v7++;
      if (out_valid_o && out_ready_i) begin
        if (got < n_out)
          check(out_data_o == exp_mem[got], tag, out_data_o, exp_mem[got]);
        got++;
      end
      if (in_valid_i && in_ready_o) sent++;
      @(negedge clk_i);
      cyc++;
    end
    in_valid_i = 1'b0;
    if (cyc >= 5000) check(1'b0, "watchdog expired", W'(cyc), W'(0));
    check(got == n_out, "R3 output count", W'(got), W'(n_out));
    check(sent == n_in, "R3 input count", W'(sent), W'(n_in));
    check(done_o && !busy_o, "R8 done after last beat", W'({done_o, busy_o}), W'(2'b10));
    check(v5 == 0, "R5 input held off while stalled", W'(v5), W'(0));
    check(v6 == 0, "R6 output stable while stalled", W'(v6), W'(0));
    if (smode == 0) check(v7 == 0, "R7 full throughput", W'(v7), W'(0));
    #1;
    check(out_valid_o == 1'b0, "R3 no extra output", W'(out_valid_o), W'(0));
  endtask

  task automatic t_reset();
    #5;
    check({out_valid_o, in_ready_o, busy_o, done_o} == 4'b0, "R9 in reset",
          W'({out_valid_o, in_ready_o, busy_o, done_o}), W'(0));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({out_valid_o, in_ready_o, busy_o, done_o} == 4'b0, "R9 after reset",
          W'({out_valid_o, in_ready_o, busy_o, done_o}), W'(0));
  endtask

  task automatic t_basic();        run_frame(2, 3, 6, 3, 0, 0, 0, "R1 lane max");       endtask
  task automatic t_passthrough();  run_frame(1, 2, 4, 1, 0, 0, 0, "R4 pass through");   endtask
  task automatic t_no_leak();      run_frame(2, 2, 8, 4, 1, 0, 0, "R2 window restart"); endtask
  task automatic t_backpressure(); run_frame(2, 2, 4, 2, 0, 1, 0, "R5 R6 stall data");  endtask
  task automatic t_cfg_sampled();  run_frame(1, 3, 6, 2, 0, 1, 1, "R10 cfg sampled");   endtask

  initial begin
    t_reset();
    t_basic();
    t_passthrough();
    t_no_leak();
    t_backpressure();
    t_cfg_sampled();
    @(negedge clk_i);
    check(done_o == 1'b1 && in_ready_o == 1'b0, "R8 done sticky while idle",
          W'({done_o, in_ready_o}), W'(2'b10));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule